// File: doc/BRIEF.md
# Decode-Stage Data Hazard Stall Unit

This block sits beside the decode stage of an in-order five-stage pipeline that has no bypass paths. Each cycle it compares the register fields of the instruction waiting in decode against the destination fields of older register-writing instructions still in flight. When the decode instruction would read a register that has not yet been written, the block raises `stall`. That holds fetch and decode in place. It also raises `bubble`, which loads a NOP into execute while the older stages keep draining.

The stall length comes from the nearest conflicting producer. A small down-counter then carries the stall until the producer's result is readable from the register file. A static mode input tells the block whether the register file is written in the first half of a cycle and read in the second. In that mode a producer in writeback no longer conflicts, and every stall is one cycle shorter. A taken-branch flush cancels a stall in progress. A data-memory freeze suspends the countdown.

Top module: `hazard_stall_unit`

## Requirements
- R1: Opcodes are 3-bit codes: NOP=0, ADD=1, SUB=2, LOAD=3, STORE=4, BR=5, BREQ=6, BRNEQ=7. Only ADD, SUB or LOAD in execute, memory or writeback counts as a producer, through its dst field. Any other opcode there never causes a stall.
- R2: A decode instruction other than NOP conflicts with a producer when its src1 or src2 field equals the producer's dst.
- R3: A decode STORE also conflicts when its dst field equals a producer's dst.
- R4: A decode BR, BREQ or BRNEQ also conflicts when its dst field equals a producer's dst. For the other decode opcodes the dst field is never compared.
- R5: With `split_rf`=0 the producers in execute, memory and writeback are all compared. With `split_rf`=1 the writeback producer is ignored.
- R6: A stall that begins while no stall is in progress lasts, counting its first cycle, 3, 2 or 1 cycles for a nearest producer in execute, memory or writeback. Each length is one less when `split_rf`=1.
- R7: When several producers conflict, the one closest to decode (execute before memory before writeback) sets the length. While a stall is in progress, new comparisons are not made.
- R8: `bubble` is high exactly when `stall` is high and `mem_busy` is low.
- R9: While `flush` is high, `stall` and `bubble` are low, and any stall in progress is cancelled.
- R10: While `mem_busy` is high, the remaining stall count does not change. `stall` stays high but no bubble is issued.
- R11: After reset no stall is in progress, so with NOPs in every stage `stall` and `bubble` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_rf | input | 1 | Register file writes in the first half-cycle and reads in the second |
| id_op | input | OP_W | Decode opcode |
| id_src1 | input | REG_W | Decode first source register |
| id_src2 | input | REG_W | Decode second source register |
| id_dst | input | REG_W | Decode dst field |
| ex_op | input | OP_W | Execute-stage opcode |
| ex_dst | input | REG_W | Execute-stage dst |
| mem_op | input | OP_W | Memory-stage opcode |
| mem_dst | input | REG_W | Memory-stage dst |
| wb_op | input | OP_W | Writeback-stage opcode |
| wb_dst | input | REG_W | Writeback-stage dst |
| mem_busy | input | 1 | Data memory not ready; whole pipeline frozen |
| flush | input | 1 | Taken branch flushing the front of the pipeline |
| stall | output | 1 | Hold fetch and decode |
| bubble | output | 1 | Insert a NOP into execute |

## Verification
The assertions assume that `split_rf` changes only while reset is applied. This matters because the bound on the remaining count, and the shortened lengths, are only meaningful for a mode that stays put. The bench therefore sets the mode before each reset and holds it through every directed and random phase. The stage inputs otherwise need not form a consistent pipeline. The checks only involve the counter, `flush` and `mem_busy`, so the random phase drives arbitrary opcodes, registers, freezes and flushes, drawn from a narrow register range so that conflicts are frequent.

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
  parameter int OP_W  = 3,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_rf,
  input  logic [OP_W-1:0]  id_op,
  input  logic [REG_W-1:0] id_src1,
  input  logic [REG_W-1:0] id_src2,
  input  logic [REG_W-1:0] id_dst,
  input  logic [OP_W-1:0]  ex_op,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [OP_W-1:0]  mem_op,
  input  logic [REG_W-1:0] mem_dst,
  input  logic [OP_W-1:0]  wb_op,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             mem_busy,
  input  logic             flush,
  output logic             stall,
  output logic             bubble
);
  localparam int CNT_W = 2;
  localparam logic [OP_W-1:0] OP_NOP = OP_W'(0), OP_ADD = OP_W'(1), OP_SUB = OP_W'(2),
    OP_LOAD = OP_W'(3), OP_STORE = OP_W'(4), OP_BR = OP_W'(5), OP_BREQ = OP_W'(6),
    OP_BRNEQ = OP_W'(7);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic dst_read, busy, hit_ex, hit_mem, hit_wb, hit;

  function automatic logic writes_reg(input logic [OP_W-1:0] op);
    return op == OP_ADD || op == OP_SUB || op == OP_LOAD;
  endfunction

  function automatic logic conflict(input logic [OP_W-1:0] op, input logic [REG_W-1:0] d,
                                    input logic rd_dst);
    return writes_reg(op) && id_op != OP_NOP &&
           (d == id_src1 || d == id_src2 || (rd_dst && d == id_dst));
  endfunction

  assign dst_read = id_op == OP_STORE || id_op == OP_BR || id_op == OP_BREQ || id_op == OP_BRNEQ;
  assign hit_ex   = conflict(ex_op, ex_dst, dst_read);
  assign hit_mem  = conflict(mem_op, mem_dst, dst_read);
  assign hit_wb   = conflict(wb_op, wb_dst, dst_read) && !split_rf;
  assign busy     = cnt_q != '0;
  assign hit      = !busy && (hit_ex || hit_mem || hit_wb);

  assign len = (hit_ex ? CNT_W'(3) : hit_mem ? CNT_W'(2) : CNT_W'(1)) - CNT_W'(split_rf);

  assign stall  = !flush && (busy || hit);
  assign bubble = stall && !mem_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (flush)    cnt_q <= '0;
    else if (mem_busy) cnt_q <= cnt_q;
    else if (busy)     cnt_q <= cnt_q - CNT_W'(1);
    else if (hit)      cnt_q <= len - CNT_W'(1);
  end
endmodule

module hazard_stall_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       split_rf,
  input logic       mem_busy,
  input logic       flush,
  input logic       stall,
  input logic       bubble,
  input logic [1:0] cnt_q
);
  assert_bubble_only_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> stall && !mem_busy);

  assert_flush_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == 2'd0);

  assert_flush_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !stall && !bubble);

  assert_freeze_holds_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy && !flush |=> $stable(cnt_q));

  assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_busy && !flush && cnt_q != 2'd0 |=> cnt_q == $past(cnt_q) - 2'd1);

  assert_pending_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 2'd0 && !flush |-> stall);

  assert_split_shorter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    split_rf |-> cnt_q <= 2'd1);
endmodule

bind hazard_stall_unit hazard_stall_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .split_rf(split_rf), .mem_busy(mem_busy), .flush(flush),
  .stall(stall), .bubble(bubble), .cnt_q(cnt_q)
);

// File: tb/hazard_stall_unit_bench.sv
module hazard_stall_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, split_rf = 1'b0, mem_busy = 1'b0, flush = 1'b0;
  logic [2:0] id_op = '0, ex_op = '0, mem_op = '0, wb_op = '0;
  logic [4:0] id_src1 = '0, id_src2 = '0, id_dst = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic stall, bubble;
  int checks = 0, fails = 0, rcnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hazard_stall_unit u_hazard_stall_unit (
    .clk(clk), .rst_n(rst_n), .split_rf(split_rf), .id_op(id_op), .id_src1(id_src1),
    .id_src2(id_src2), .id_dst(id_dst), .ex_op(ex_op), .ex_dst(ex_dst), .mem_op(mem_op),
    .mem_dst(mem_dst), .wb_op(wb_op), .wb_dst(wb_dst), .mem_busy(mem_busy), .flush(flush),
    .stall(stall), .bubble(bubble)
  );

  function automatic int ref_len();
    int ops[3], dsts[3];
    bit rd_dst;
    ops = '{int'(ex_op), int'(mem_op), int'(wb_op)};
    dsts = '{int'(ex_dst), int'(mem_dst), int'(wb_dst)};
    rd_dst = id_op >= 4;
    if (id_op == 0) return 0;
    for (int k = 0; k < 3; k++) begin
      if (k == 2 && split_rf) continue;
      if (ops[k] >= 1 && ops[k] <= 3 &&
          (dsts[k] == id_src1 || dsts[k] == id_src2 || (rd_dst && dsts[k] == id_dst)))
        return 3 - k - int'(split_rf);
    end
    return 0;
  endfunction

  task automatic id_set(input int op, input int s1, input int s2, input int d);
    id_op = 3'(op); id_src1 = 5'(s1); id_src2 = 5'(s2); id_dst = 5'(d);
  endtask

  task automatic stages(input int eo, input int ed, input int mo, input int md,
                        input int wo, input int wd);
    ex_op = 3'(eo); ex_dst = 5'(ed); mem_op = 3'(mo); mem_dst = 5'(md);
    wb_op = 3'(wo); wb_dst = 5'(wd);
  endtask

  task automatic cyc(input string tag);
    int l;
    bit es, eb;
    #1;
    l = ref_len();
    es = !flush && (rcnt > 0 || (rcnt == 0 && l > 0));
    eb = es && !mem_busy;
    checks++;
    if (stall !== es || bubble !== eb) begin
      fails++;
      $display("FAIL %s: stall=%b bubble=%b expected stall=%b bubble=%b", tag, stall, bubble, es, eb);
    end
    if (flush) rcnt = 0;
    else if (mem_busy) rcnt = rcnt;
    else if (rcnt > 0) rcnt--;
    else if (l > 0) rcnt = l - 1;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit split);
    rst_n = 1'b0; split_rf = split; mem_busy = 0; flush = 0;
    id_set(0, 0, 0, 0); stages(0, 0, 0, 0, 0, 0);
    rcnt = 0;
    @(negedge clk); @(negedge clk);
    cyc("R11");
    rst_n = 1'b1;
    cyc("R11");
  endtask

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      id_set($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
      stages($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 7),
             $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3));
      mem_busy = ($urandom_range(0, 7) == 0);
      flush = ($urandom_range(0, 15) == 0);
      cyc("R2 random");
    end
    mem_busy = 0; flush = 0; id_set(0, 0, 0, 0); stages(0, 0, 0, 0, 0, 0);
    repeat (3) cyc("R6 drain");
  endtask

  initial begin
    @(negedge clk);
    do_reset(0);
    // R2: src1 vs ADD in execute, producer moves along; 3-cycle stall (R6)
    id_set(1, 3, 4, 9); stages(1, 3, 0, 0, 0, 0); cyc("R2");
    stages(0, 0, 1, 3, 0, 0); cyc("R6");
    stages(0, 0, 0, 0, 1, 3); cyc("R6");
    stages(0, 0, 0, 0, 0, 0); cyc("R6 end");
    // R1: STORE and branch in later stages do not produce
    id_set(2, 5, 6, 0); stages(4, 5, 5, 6, 7, 5); cyc("R1");
    // R2: src2 vs LOAD in memory: 2 cycles
    id_set(3, 1, 7, 0); stages(0, 0, 3, 7, 0, 0); cyc("R2");
    stages(0, 0, 0, 0, 3, 7); cyc("R6");
    stages(0, 0, 0, 0, 0, 0); cyc("R6 end");
    // R4: dst of ADD not compared; dst of BREQ is
    id_set(1, 1, 2, 8); stages(2, 8, 0, 0, 0, 0); cyc("R4 add dst");
    id_set(6, 1, 2, 8); cyc("R4 breq dst");
    stages(0, 0, 2, 8, 0, 0); cyc("R4");
    stages(0, 0, 0, 0, 2, 8); cyc("R4");
    stages(0, 0, 0, 0, 0, 0); cyc("R4 end");
    // R3: STORE dst vs WB producer: 1 cycle
    id_set(4, 1, 2, 11); stages(0, 0, 0, 0, 1, 11); cyc("R3");
    stages(0, 0, 0, 0, 0, 0); cyc("R3 end");
    // R7: EX and WB both conflict; EX sets length 3
    id_set(5, 1, 2, 6); stages(1, 6, 0, 0, 1, 2); cyc("R7");
    stages(0, 0, 1, 6, 0, 0); cyc("R7");
    stages(0, 0, 0, 0, 1, 6); cyc("R7");
    stages(0, 0, 0, 0, 0, 0); cyc("R7 end");
    // R10: freeze keeps count, no bubble
    id_set(1, 4, 0, 0); stages(1, 4, 0, 0, 0, 0); cyc("R10");
    mem_busy = 1; stages(0, 0, 1, 4, 0, 0); cyc("R10 frozen");
    cyc("R10 frozen");
    mem_busy = 0; cyc("R10");
    stages(0, 0, 0, 0, 1, 4); cyc("R10");
    stages(0, 0, 0, 0, 0, 0); cyc("R10 end");
    // R9: flush cancels
    id_set(1, 4, 0, 0); stages(1, 4, 0, 0, 0, 0); cyc("R9");
    flush = 1; id_set(0, 0, 0, 0); stages(0, 0, 1, 4, 0, 0); cyc("R9 flush");
    flush = 0; stages(0, 0, 0, 0, 1, 4); cyc("R9 after");
    stages(0, 0, 0, 0, 0, 0);
    random_phase(800);

    do_reset(1);
    // R5: WB producer ignored in split mode
    id_set(1, 9, 0, 0); stages(0, 0, 0, 0, 1, 9); cyc("R5");
    // R6: EX producer gives 2 cycles in split mode
    stages(3, 9, 0, 0, 0, 0); cyc("R6 split");
    stages(0, 0, 3, 9, 0, 0); cyc("R6 split");
    stages(0, 0, 0, 0, 3, 9); cyc("R6 split end");
    stages(0, 0, 0, 0, 0, 0);
    random_phase(800);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: R11 run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule